// File: doc/BRIEF.md
# Multi-Frame Synchronous Buffer Pointer Manager

This block tracks the read and write positions of a single synchronous streaming channel whose circular buffer lives inside a shared 16K-byte byte-wide data memory. The buffer is split into four equal sub-buffers. Each sub-buffer holds m frames of a configured number of bytes. A producer pushes bytes through a valid/ready write port and a consumer pulls bytes through a valid/ready read port. The block issues absolute memory addresses for both sides. It decides when each side may move.

Flow is counted in whole sub-buffers, not in bytes. The consumer sees data only after the producer has completed a whole sub-buffer. The producer stalls once four completed sub-buffers are still waiting to be read. A mute setting replaces the stored bytes with zeros on the write side and replaces the returned bytes with zeros on the read side. The shared memory sits outside the block. Its write strobe, addresses and data pass through the ports, and read data comes back combinationally.

Configuration is expected to stay fixed while the channel runs. Pointers, counters and the error flag return to zero only on reset.

Top module: `sync_subbuf_ptr_mgr`

## Requirements
- R1: The write address equals the base plus the write pointer, and the read address equals the base plus the read pointer, both taken modulo 16384 (14 bits).
- R2: Both pointers are zero after reset. A pointer that sits at the depth value returns to zero on its next transfer.
- R3: With multi-frame mode on, frame-count code k (0 to 6) gives a sub-buffer of 2^k × bytes-per-frame bytes, and code 7 gives 64 × bytes-per-frame bytes.
- R4: With multi-frame mode off, a sub-buffer holds exactly one frame of bytes-per-frame bytes, whatever the frame-count code.
- R5: The read port asserts rd_valid only when at least one completed sub-buffer is unread. A partially written sub-buffer is never offered.
- R6: While four completed sub-buffers are unread, wr_ready is low and a presented write produces no memory write strobe.
- R7: Bytes are read back in the order they were written. After everything written has been read, rd_valid is low again.
- R8: With mute set, the memory write data is zero for every accepted write.
- R9: With mute set, rd_data is zero whatever the memory returns.
- R10: The status outputs are {3: error, 2: 0, 1: enabled, 0: mute} for the write side and {3: 0, 2: 0, 1: enabled, 0: mute} for the read side. Bit 1 low means idle.
- R11: Presenting wr_valid while the channel is disabled sets write status bit 3. The bit stays set until reset, and no memory write occurs.
- R12: The 2-bit write and read sub-buffer counters start at zero and advance by one each time their side completes a sub-buffer, wrapping modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Channel enable |
| cfg_base | input | 14 | Buffer base byte address |
| cfg_depth | input | 12 | Buffer size in bytes minus one |
| cfg_fcnt | input | 3 | Frame-count code |
| cfg_bpf | input | 8 | Bytes per frame |
| cfg_mfe | input | 1 | Multi-frame per sub-buffer enable |
| cfg_mute | input | 1 | Mute both sides |
| wr_valid | input | 1 | Producer byte valid |
| wr_data | input | 8 | Producer byte |
| wr_ready | output | 1 | Write accepted this cycle |
| rd_valid | output | 1 | Byte available to consumer |
| rd_ready | input | 1 | Consumer takes byte |
| rd_data | output | 8 | Byte to consumer |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 14 | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| mem_rd_addr | output | 14 | Memory read address |
| mem_rd_data | input | 8 | Memory read data |
| wr_sbc | output | 2 | Write sub-buffer counter |
| rd_sbc | output | 2 | Read sub-buffer counter |
| wr_sts | output | 4 | Write-side status |
| rd_sts | output | 4 | Read-side status |

## Verification
The hardest state to reach is the full boundary: four completed, unread sub-buffers, with the write pointer folded back to offset zero and the write sub-buffer counter wrapped to zero, all while the base sits near the top of memory so that the addresses also wrap. The bench places the base 16 bytes below the end of memory, uses 3-byte frames with two frames per sub-buffer, and writes 24 bytes without reading. It then probes a refused write, drains every byte in order, and checks that the next write lands back at the base.

// File: rtl/sync_subbuf_ptr_mgr.sv
module sync_subbuf_ptr_mgr #(
  parameter int AW   = 14,
  parameter int PW   = 12,
  parameter int DW   = 8,
  parameter int BPFW = 8,
  parameter int FCW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [AW-1:0]   cfg_base,
  input  logic [PW-1:0]   cfg_depth,
  input  logic [FCW-1:0]  cfg_fcnt,
  input  logic [BPFW-1:0] cfg_bpf,
  input  logic            cfg_mfe,
  input  logic            cfg_mute,
  input  logic            wr_valid,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_ready,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [DW-1:0]   rd_data,
  output logic            mem_wr_en,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [DW-1:0]   mem_wr_data,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic [DW-1:0]   mem_rd_data,
  output logic [1:0]      wr_sbc,
  output logic [1:0]      rd_sbc,
  output logic [3:0]      wr_sts,
  output logic [3:0]      rd_sts
);
  localparam int NSB   = 4;
  localparam int FILLW = $clog2(NSB + 1);
  localparam int MAXK  = 6;

  logic [PW-1:0]    wptr, rptr, wofs, rofs, sub_last;
  logic [FCW-1:0]   k;
  logic [FILLW-1:0] fill;
  logic [1:0]       wsbc, rsbc;
  logic             werr, wr_fire, rd_fire, wdone, rdone;

  assign k        = !cfg_mfe ? '0 : (cfg_fcnt > FCW'(MAXK) ? FCW'(MAXK) : cfg_fcnt);
  assign sub_last = (PW'(cfg_bpf) << k) - 1'b1;

  assign wr_ready = cfg_en && (fill != FILLW'(NSB));
  assign rd_valid = cfg_en && (fill != '0);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_ready && rd_valid;
  assign wdone    = wr_fire && (wofs == sub_last);
  assign rdone    = rd_fire && (rofs == sub_last);

  assign mem_wr_en   = wr_fire;
  assign mem_wr_addr = cfg_base + AW'(wptr);
  assign mem_wr_data = cfg_mute ? '0 : wr_data;
  assign mem_rd_addr = cfg_base + AW'(rptr);
  assign rd_data     = cfg_mute ? '0 : mem_rd_data;

  assign wr_sbc = wsbc;
  assign rd_sbc = rsbc;
  assign wr_sts = {werr, 1'b0, cfg_en, cfg_mute};
  assign rd_sts = {2'b00, cfg_en, cfg_mute};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      wofs <= '0;
      rofs <= '0;
      wsbc <= '0;
      rsbc <= '0;
      fill <= '0;
      werr <= 1'b0;
    end else begin
      if (wr_fire) begin
        wptr <= (wptr == cfg_depth) ? '0 : wptr + 1'b1;
        wofs <= wdone ? '0 : wofs + 1'b1;
        if (wdone) wsbc <= wsbc + 1'b1;
      end
      if (rd_fire) begin
        rptr <= (rptr == cfg_depth) ? '0 : rptr + 1'b1;
        rofs <= rdone ? '0 : rofs + 1'b1;
        if (rdone) rsbc <= rsbc + 1'b1;
      end
      case ({wdone, rdone})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (wr_valid && !cfg_en) werr <= 1'b1;
    end
  end

  p_wptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wptr == cfg_depth) |=> (mem_wr_addr == cfg_base));
  p_rptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rptr == cfg_depth) |=> (mem_rd_addr == cfg_base));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FILLW'(NSB) && !rd_fire) |=> (fill == FILLW'(NSB) && $stable(wptr)));
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILLW'(NSB));
  p_partial_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && !wdone) |=> !rd_valid);
  p_sbc_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wdone |=> (wr_sbc == $past(wr_sbc) + 2'd1));
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts[3] |=> wr_sts[3]);
  p_mute_wdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && cfg_mute) |-> (mem_wr_data == '0));
endmodule

// File: tb/sync_subbuf_ptr_mgr_tb.sv
`timescale 1ns/1ps
module sync_subbuf_ptr_mgr_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b1, cfg_mfe = 1'b0, cfg_mute = 1'b0;
  logic [13:0] cfg_base = '0;
  logic [11:0] cfg_depth = 12'd3;
  logic [2:0]  cfg_fcnt = '0;
  logic [7:0]  cfg_bpf = 8'd1;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, rd_valid, mem_wr_en;
  logic [7:0] rd_data, mem_wr_data, mem_rd_data;
  logic [13:0] mem_wr_addr, mem_rd_addr;
  logic [1:0] wr_sbc, rd_sbc;
  logic [3:0] wr_sts, rd_sts;
  logic [7:0] mem [0:16383];
  int checks = 0, bad = 0;

  always #5 clk = ~clk;

  sync_subbuf_ptr_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_depth(cfg_depth),
    .cfg_fcnt(cfg_fcnt), .cfg_bpf(cfg_bpf), .cfg_mfe(cfg_mfe), .cfg_mute(cfg_mute),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .wr_sbc(wr_sbc), .rd_sbc(rd_sbc), .wr_sts(wr_sts), .rd_sts(rd_sts));

  always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
  assign mem_rd_data = mem[mem_rd_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(mem_wr_addr == cfg_base && mem_rd_addr == cfg_base, "R2", mem_wr_addr, cfg_base);
    chk(wr_sbc == 0 && rd_sbc == 0, "R12", {wr_sbc, rd_sbc}, 0);
    chk(!rd_valid && wr_ready, "R5", {rd_valid, wr_ready}, 1);
    chk(wr_sts == 4'b0010 && rd_sts == 4'b0010, "R10", {wr_sts, rd_sts}, 8'h22);
  endtask

  task automatic t_fill_drain();
    int wp;
    cfg_base = 14'h3FF0; cfg_bpf = 8'd3; cfg_mfe = 1'b1; cfg_fcnt = 3'd1; cfg_depth = 12'd23;
    do_reset();
    wp = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); wr_valid = 1'b1; wr_data = 8'h10 + 8'(i); #1;
      chk(mem_wr_en, "R6", mem_wr_en, 1);
      chk(mem_wr_addr == 14'((16'h3FF0 + wp)), "R1", mem_wr_addr, 14'(16'h3FF0 + wp));
      if (i == 5) chk(!rd_valid, "R5", rd_valid, 0);
      @(posedge clk); #1 wr_valid = 1'b0;
      wp++;
      if (i == 5) chk(rd_valid && wr_sbc == 2'd1, "R5", {rd_valid, wr_sbc}, 5);
    end
    chk(wr_sbc == 2'd0, "R12", wr_sbc, 0);
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'hEE; #1;
    chk(!wr_ready && !mem_wr_en, "R6", {wr_ready, mem_wr_en}, 0);
    @(posedge clk); #1 wr_valid = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); rd_ready = 1'b1; #1;
      chk(rd_valid && rd_data == 8'h10 + 8'(i), "R7", rd_data, 8'h10 + 8'(i));
      chk(mem_rd_addr == 14'(16'h3FF0 + i), "R1", mem_rd_addr, 14'(16'h3FF0 + i));
      @(posedge clk); #1 rd_ready = 1'b0;
      if (i == 5) chk(rd_sbc == 2'd1, "R12", rd_sbc, 1);
    end
    chk(!rd_valid && rd_sbc == 2'd0, "R7", {rd_valid, rd_sbc}, 0);
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'h77; #1;
    chk(mem_wr_addr == 14'h3FF0, "R2", mem_wr_addr, 14'h3FF0);
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic sub_size(input bit mfe, input logic [2:0] fc, input logic [7:0] bpf, input int expn, input string req);
    cfg_base = 14'h0100; cfg_mfe = mfe; cfg_fcnt = fc; cfg_bpf = bpf; cfg_depth = 12'(4 * expn - 1);
    do_reset();
    for (int i = 0; i < expn - 1; i++) wr_byte(8'(i));
    chk(!rd_valid, req, rd_valid, 0);
    wr_byte(8'hFF);
    chk(rd_valid && wr_sbc == 2'd1, req, {rd_valid, wr_sbc}, 5);
  endtask

  task automatic t_mute();
    cfg_base = 14'h0200; cfg_mfe = 1'b0; cfg_bpf = 8'd1; cfg_depth = 12'd3; cfg_mute = 1'b0;
    do_reset();
    wr_byte(8'h5A);
    @(negedge clk); cfg_mute = 1'b1; #1;
    chk(rd_valid && rd_data == 8'h00, "R9", rd_data, 0);
    chk(wr_sts[0] && rd_sts[0], "R10", {wr_sts[0], rd_sts[0]}, 3);
    wr_valid = 1'b1; wr_data = 8'hAA; #1;
    chk(mem_wr_en && mem_wr_data == 8'h00, "R8", mem_wr_data, 0);
    @(posedge clk); #1 wr_valid = 1'b0;
    @(negedge clk); cfg_mute = 1'b0; #1;
    chk(rd_data == 8'h5A, "R9", rd_data, 8'h5A);
  endtask

  task automatic t_disabled();
    do_reset();
    @(negedge clk); cfg_en = 1'b0; #1;
    chk(!wr_ready && !wr_sts[1] && !rd_sts[1], "R10", {wr_ready, wr_sts[1], rd_sts[1]}, 0);
    wr_valid = 1'b1; wr_data = 8'h33; #1;
    chk(!mem_wr_en, "R11", mem_wr_en, 0);
    @(posedge clk); #1 wr_valid = 1'b0;
    @(negedge clk); cfg_en = 1'b1; #1;
    chk(wr_sts == 4'b1010, "R11", wr_sts, 4'hA);
    chk(!rd_valid && mem_wr_addr == cfg_base, "R11", mem_wr_addr, cfg_base);
    repeat (3) @(posedge clk);
    #1 chk(wr_sts[3], "R11", wr_sts[3], 1);
  endtask

  initial begin
    t_reset();
    t_fill_drain();
    sub_size(1'b1, 3'd2, 8'd2, 8, "R3");
    sub_size(1'b1, 3'd7, 8'd1, 64, "R3");
    sub_size(1'b0, 3'd3, 8'd4, 4, "R4");
    t_mute();
    t_disabled();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule